// File: doc/BRIEF.md
# Predicate-Result Write Controller

This block decides, element by element, what a vectorised arithmetic operation commits: the element's result, a zero in place of the result, and the element's condition field. It combines the ordinary predicate mask with a test on one selected bit of the condition field that is derived from each freshly computed result. A failed test acts as if the element's destination predicate bit had been clear. Even so, when condition storage is enabled the condition field itself is still committed, so that later code can inspect which elements failed.

A run starts with a one-cycle `start_i` pulse that captures the vector length, the mask and the mode controls. The controller then presents one element index per cycle on `elem_idx_o`, starting at 0. A datapath stub answers combinationally on `res_i` and `so_i`. One cycle later the registered write decision for that element appears on the output side. Every element is decided independently of the others. The sequential walk exists only to match a one-result-per-cycle datapath.

Top module: `pred_result_wctl`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `out_valid_o` are low and stay low until a start is accepted.
- R2: The condition field is computed from the result as `cr_o[3]`=less than zero (sign bit set), `cr_o[2]`=greater than zero, `cr_o[1]`=equal to zero, `cr_o[0]`=the datapath's `so_i` for that element.
- R3: For an element whose mask bit is 1, `cr_we_o` is 1 whenever `rc_i` or `rc1_i` was set at start, whether the test passes or fails.
- R4: `res_we_o` is 1 only for an element whose mask bit is 1, with `rc1_i`=0, and whose selected condition bit differs from `inv_i`. `sel_i` encodes 0=lt, 1=gt, 2=eq, 3=so. When `res_we_o` is 1, `wdata_o` carries the result.
- R5: With `rc1_i`=1, neither `res_we_o` nor `zero_we_o` is ever asserted. Only the condition field may be written.
- R6: With `zero_en_i`=1 and `rc1_i`=0, an element that is masked out or fails the test gets `zero_we_o`=1 with `wdata_o`=0. With `zero_en_i`=0, `zero_we_o` stays 0.
- R7: An element whose mask bit is 0 is skipped: `res_we_o`=0 and `cr_we_o`=0.
- R8: The controller walks indices 0 to VL-1, one per cycle. The decision for the index shown on `elem_idx_o` appears one cycle later with `out_valid_o`=1 and `out_idx_o` equal to that index. No output is produced outside a run.
- R9: `done_o` pulses for exactly one cycle, together with the decision for the last element. With VL=0 it pulses in the cycle after the start, and no element is produced.
- R10: `res_we_o` and `zero_we_o` are never both 1 for the same element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a run; accepted only when idle |
| vl_i | input | VLW | Vector length (0..MAXVL) |
| pred_mask_i | input | MAXVL | Predicate mask, bit i for element i |
| zero_en_i | input | 1 | Predicate zeroing enable |
| rc_i | input | 1 | Store condition fields |
| rc1_i | input | 1 | Condition-only mode: store condition fields, never results |
| sel_i | input | 2 | Tested condition bit: 0 lt, 1 gt, 2 eq, 3 so |
| inv_i | input | 1 | Test passes when selected bit differs from this flag |
| busy_o | output | 1 | Run in progress |
| elem_idx_o | output | IDXW | Element index requested from the datapath |
| res_i | input | XLEN | Datapath result for `elem_idx_o` |
| so_i | input | 1 | Datapath overflow/summary bit for `elem_idx_o` |
| out_valid_o | output | 1 | Decision for one element is valid |
| out_idx_o | output | IDXW | Element index of the decision |
| res_we_o | output | 1 | Write result to destination |
| zero_we_o | output | 1 | Write zero to destination |
| cr_we_o | output | 1 | Write condition field |
| cr_o | output | 4 | Condition field {lt, gt, eq, so} |
| wdata_o | output | XLEN | Destination data (result or zero) |
| done_o | output | 1 | Single-cycle end-of-run pulse |

## Verification
The result pattern cycles through zero, positive, negative and large-positive values, so that each run sees every outcome of the lt, gt and eq tests. All four bit selections are tried with both invert settings, which separates a passed test from a failed one. Dense, sparse and empty masks are run with zeroing both on and off. These runs show apart a skipped element, a zeroed element and a written element. Condition-only runs show that the condition field is committed while the destination never is. Runs with VL=0, VL=1 and VL=MAXVL cover the ends of the length range and the placement of the done pulse.

// File: rtl/prw_pkg.sv
package prw_pkg;
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;

  typedef enum logic [1:0] {
    SEL_LT = 2'd0,
    SEL_GT = 2'd1,
    SEL_EQ = 2'd2,
    SEL_SO = 2'd3
  } bit_sel_e;

  typedef struct packed {
    logic res_we;
    logic zero_we;
    logic cr_we;
  } wr_t;

  function automatic logic pick_bit(cond_t c, bit_sel_e s);
    case (s)
      SEL_LT:  pick_bit = c.lt;
      SEL_GT:  pick_bit = c.gt;
      SEL_EQ:  pick_bit = c.eq;
      default: pick_bit = c.so;
    endcase
  endfunction
endpackage

// File: rtl/prw_cond_analyse.sv
module prw_cond_analyse
  import prw_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] res_i,
  input  logic            so_i,
  output cond_t           cond_o
);
  logic is_zero;
  assign is_zero   = (res_i == '0);
  assign cond_o.lt = res_i[XLEN-1];
  assign cond_o.eq = is_zero;
  assign cond_o.gt = !res_i[XLEN-1] && !is_zero;
  assign cond_o.so = so_i;
endmodule

// File: rtl/prw_elem_decide.sv
module prw_elem_decide
  import prw_pkg::*;
(
  input  logic     active_i,
  input  cond_t    cond_i,
  input  logic     zero_en_i,
  input  logic     rc_i,
  input  logic     rc1_i,
  input  bit_sel_e sel_i,
  input  logic     inv_i,
  output wr_t      wr_o
);
  logic pass;
  logic keep;
  assign pass        = (pick_bit(cond_i, sel_i) != inv_i);
  // a failed test behaves like a cleared predicate bit
  assign keep        = active_i && pass;
  assign wr_o.cr_we  = active_i && (rc_i || rc1_i);
  assign wr_o.res_we = keep && !rc1_i;
  assign wr_o.zero_we = zero_en_i && !rc1_i && !keep;
endmodule

// File: rtl/prw_elem_seq.sv
module prw_elem_seq #(
  parameter int MAXVL = 64,
  localparam int VLW  = $clog2(MAXVL + 1),
  localparam int IDXW = $clog2(MAXVL)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [VLW-1:0]  vl_i,
  output logic            busy_o,
  output logic [IDXW-1:0] idx_o,
  output logic            done_o
);
  logic [VLW-1:0]  vl_q;
  logic [VLW-1:0]  vl_lim;
  logic [IDXW-1:0] idx_q;
  logic            busy_q;
  logic            done_q;
  logic            at_last;

  assign vl_lim  = (vl_i > VLW'(MAXVL)) ? VLW'(MAXVL) : vl_i;
  assign at_last = (VLW'(idx_q) + VLW'(1)) == vl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      vl_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        idx_q <= '0;
        vl_q  <= vl_lim;
        if (vl_lim == '0) done_q <= 1'b1;
        else              busy_q <= 1'b1;
      end else if (busy_q) begin
        if (at_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + IDXW'(1);
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign done_o = done_q;

  // R8
  idx_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (VLW'(idx_q) < vl_q))
    else $error("element index beyond VL");

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q)
    else $error("done while busy");
endmodule

// File: rtl/pred_result_wctl.sv
module pred_result_wctl
  import prw_pkg::*;
#(
  parameter int MAXVL = 64,
  parameter int XLEN  = 32,
  localparam int VLW  = $clog2(MAXVL + 1),
  localparam int IDXW = $clog2(MAXVL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VLW-1:0]   vl_i,
  input  logic [MAXVL-1:0] pred_mask_i,
  input  logic             zero_en_i,
  input  logic             rc_i,
  input  logic             rc1_i,
  input  logic [1:0]       sel_i,
  input  logic             inv_i,
  output logic             busy_o,
  output logic [IDXW-1:0]  elem_idx_o,
  input  logic [XLEN-1:0]  res_i,
  input  logic             so_i,
  output logic             out_valid_o,
  output logic [IDXW-1:0]  out_idx_o,
  output logic             res_we_o,
  output logic             zero_we_o,
  output logic             cr_we_o,
  output logic [3:0]       cr_o,
  output logic [XLEN-1:0]  wdata_o,
  output logic             done_o
);
  logic [MAXVL-1:0] mask_q;
  logic             zero_q, rc_q, rc1_q, inv_q;
  bit_sel_e         sel_q;
  logic             seq_busy;
  logic [IDXW-1:0]  seq_idx;
  logic             seq_done;
  logic             take;
  cond_t            cond;
  wr_t              wr;

  assign take = start_i && !seq_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      zero_q <= 1'b0;
      rc_q   <= 1'b0;
      rc1_q  <= 1'b0;
      inv_q  <= 1'b0;
      sel_q  <= SEL_LT;
    end else if (take) begin
      mask_q <= pred_mask_i;
      zero_q <= zero_en_i;
      rc_q   <= rc_i;
      rc1_q  <= rc1_i;
      inv_q  <= inv_i;
      sel_q  <= bit_sel_e'(sel_i);
    end
  end

  prw_elem_seq #(.MAXVL(MAXVL)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .vl_i   (vl_i),
    .busy_o (seq_busy),
    .idx_o  (seq_idx),
    .done_o (seq_done)
  );

  prw_cond_analyse #(.XLEN(XLEN)) u_cond (
    .res_i (res_i),
    .so_i  (so_i),
    .cond_o(cond)
  );

  prw_elem_decide u_dec (
    .active_i (mask_q[seq_idx]),
    .cond_i   (cond),
    .zero_en_i(zero_q),
    .rc_i     (rc_q),
    .rc1_i    (rc1_q),
    .sel_i    (sel_q),
    .inv_i    (inv_q),
    .wr_o     (wr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_idx_o   <= '0;
      res_we_o    <= 1'b0;
      zero_we_o   <= 1'b0;
      cr_we_o     <= 1'b0;
      cr_o        <= '0;
      wdata_o     <= '0;
    end else begin
      out_valid_o <= seq_busy;
      res_we_o    <= seq_busy && wr.res_we;
      zero_we_o   <= seq_busy && wr.zero_we;
      cr_we_o     <= seq_busy && wr.cr_we;
      if (seq_busy) begin
        out_idx_o <= seq_idx;
        cr_o      <= cond;
        wdata_o   <= wr.res_we ? res_i : '0;
      end
    end
  end

  assign busy_o     = seq_busy;
  assign elem_idx_o = seq_idx;
  assign done_o     = seq_done;

  // R10
  we_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_we_o && zero_we_o))
    else $error("result and zero write together");

  // R5
  rc1_no_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && rc1_q) |-> (!res_we_o && !zero_we_o))
    else $error("destination written in condition-only mode");

  // R7
  masked_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_busy && !mask_q[seq_idx]) |=> (!res_we_o && !cr_we_o))
    else $error("masked element written");

  // R3
  cr_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_busy && mask_q[seq_idx] && (rc_q || rc1_q)) |=> cr_we_o)
    else $error("condition field not committed");

  // R8
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && $past(out_valid_o)) |-> (out_idx_o == $past(out_idx_o) + IDXW'(1)))
    else $error("element order broken");

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(seq_busy) |-> !out_valid_o)
    else $error("output outside a run");
endmodule

// File: tb/pred_result_wctl_test.sv
`timescale 1ns/1ps
module pred_result_wctl_test;
  localparam int MAXVL = 64;
  localparam int XLEN  = 32;
  localparam int VLW   = $clog2(MAXVL + 1);
  localparam int IDXW  = $clog2(MAXVL);

  typedef struct {
    int              idx;
    logic            active;
    logic            rc1;
    logic            res_we;
    logic            zero_we;
    logic            cr_we;
    logic [3:0]      cr;
    logic [XLEN-1:0] wdata;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [VLW-1:0] vl = '0;
  logic [MAXVL-1:0] mask = '0;
  logic zero_en = 1'b0, rc = 1'b0, rc1 = 1'b0, inv = 1'b0;
  logic [1:0] sel = 2'd0;
  logic busy, out_valid, res_we, zero_we, cr_we, done;
  logic [IDXW-1:0] elem_idx, out_idx;
  logic [XLEN-1:0] res, wdata;
  logic so;
  logic [3:0] cr;

  logic [XLEN-1:0] res_arr [MAXVL];
  logic            so_arr  [MAXVL];
  exp_t            sb [$];
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign res = res_arr[elem_idx];
  assign so  = so_arr[elem_idx];

  pred_result_wctl #(.MAXVL(MAXVL), .XLEN(XLEN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vl_i(vl),
    .pred_mask_i(mask), .zero_en_i(zero_en), .rc_i(rc), .rc1_i(rc1),
    .sel_i(sel), .inv_i(inv), .busy_o(busy), .elem_idx_o(elem_idx),
    .res_i(res), .so_i(so), .out_valid_o(out_valid), .out_idx_o(out_idx),
    .res_we_o(res_we), .zero_we_o(zero_we), .cr_we_o(cr_we), .cr_o(cr),
    .wdata_o(wdata), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (out_valid) begin
        if (sb.size() == 0) begin
          chk(0, "R8 unexpected element", longint'(out_idx), -1);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(int'(out_idx) == e.idx, "R8 element index", out_idx, e.idx);
          chk(cr_we == e.cr_we, "R3 cr_we", cr_we, e.cr_we);
          if (e.cr_we) chk(cr == e.cr, "R2 condition field", cr, e.cr);
          chk(res_we == e.res_we, "R4 res_we", res_we, e.res_we);
          chk(zero_we == e.zero_we, "R6 zero_we", zero_we, e.zero_we);
          if (e.res_we || e.zero_we) chk(wdata == e.wdata, "R6 wdata", wdata, e.wdata);
          chk(!(res_we && zero_we), "R10 exclusive enables", {res_we, zero_we}, 0);
          if (e.rc1) chk(!res_we && !zero_we, "R5 condition-only", {res_we, zero_we}, 0);
          if (!e.active) chk(!res_we && !cr_we, "R7 masked skip", {res_we, cr_we}, 0);
        end
      end
    end
  end

  task automatic run_vec(input int n, input logic [MAXVL-1:0] m, input logic z,
                         input logic c, input logic c1, input logic [1:0] s,
                         input logic iv, input int kind);
    int cyc;
    for (int i = 0; i < MAXVL; i++) begin
      case ((i + kind) % 4)
        0: res_arr[i] = '0;
        1: res_arr[i] = XLEN'(i + 1);
        2: res_arr[i] = -XLEN'(i + 1);
        default: res_arr[i] = XLEN'(32'h7FFF_FFF0 - i);
      endcase
      so_arr[i] = ((i * 3 + kind) % 5) == 0;
    end
    for (int i = 0; i < n; i++) begin
      exp_t e;
      logic lt, gt, eq, pass, keep;
      lt = res_arr[i][XLEN-1];
      eq = (res_arr[i] == '0);
      gt = !lt && !eq;
      e.cr = {lt, gt, eq, so_arr[i]};
      pass = (e.cr[3 - int'(s)] != iv);
      keep = m[i] && pass;
      e.idx = i;
      e.active = m[i];
      e.rc1 = c1;
      e.cr_we = m[i] && (c || c1);
      e.res_we = keep && !c1;
      e.zero_we = z && !c1 && !keep;
      e.wdata = e.res_we ? res_arr[i] : '0;
      sb.push_back(e);
    end
    @(negedge clk);
    start = 1'b1; vl = VLW'(n); mask = m; zero_en = z; rc = c; rc1 = c1; sel = s; inv = iv;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < n + 10) begin
      @(negedge clk);
      cyc++;
    end
    chk(done && cyc == n + 1, "R9 done timing", cyc, n + 1);
    @(negedge clk);
    chk(!done && !busy, "R9 single done pulse", {done, busy}, 0);
    chk(sb.size() == 0, "R8 all elements produced", sb.size(), 0);
    sb.delete();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MAXVL; i++) begin
      res_arr[i] = '0;
      so_arr[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !out_valid, "R1 reset state", {busy, done, out_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !out_valid, "R1 idle after reset", {busy, done, out_valid}, 0);

    // full mask, store cr, pass when not equal to zero
    run_vec(12, '1, 1'b0, 1'b1, 1'b0, 2'd2, 1'b1, 0);
    // sparse mask, zeroing, pass when negative
    run_vec(16, 64'hA5C3_0F0F_1234_8421, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1);
    // condition-only with zeroing requested
    run_vec(10, 64'h0000_0000_0000_03B7, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 2);
    // test the so bit, inverted
    run_vec(20, 64'hFFFF_FFFF_FFF7_FEFF, 1'b0, 1'b1, 1'b0, 2'd3, 1'b1, 3);
    // gt test inverted, zeroing, rc
    run_vec(9, 64'h0000_0000_0000_01EF, 1'b1, 1'b1, 1'b0, 2'd1, 1'b1, 1);
    // empty mask with zeroing: every element zeroed, nothing else
    run_vec(7, '0, 1'b1, 1'b1, 1'b0, 2'd2, 1'b0, 0);
    // VL=0: no elements, done one cycle later
    run_vec(0, '1, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 0);
    // VL=1
    run_vec(1, 64'h1, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 0);
    // VL=MAXVL
    run_vec(MAXVL, 64'hDEAD_BEEF_F00D_CAFE, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 2);
    // condition-only, full length, eq test
    run_vec(MAXVL, '1, 1'b0, 1'b1, 1'b1, 2'd2, 1'b0, 3);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule